// File: doc/BRIEF.md
# Shadow Bank Copy and Checksum Engine

The engine holds a live configuration register file of sixteen bytes and eight shadow RAM banks of the same size. A host hands it one-byte opcodes on a byte-valid input. One opcode restores the register file from a chosen bank. A second sums one chosen bank into an 8-bit checksum. A third sums every bank into a single checksum. Each operation moves one byte per clock. While it runs, a busy flag is high. A checksum result comes back as one byte with a single-cycle valid strobe.

The checksum adds bytes modulo 256. Before each byte is added, the status and identity bits of that byte are cleared. These are the upper nibble and bit 0 of in-bank offset 0, and all of offset 4. A side port gives direct byte access to the banks and to the register file, so their contents can be loaded and inspected.

Top module: `cfg_shadow_engine`

## Requirements
- R1: After reset, `busy` and `res_valid` are low.
- R2: Opcode `1100_0bbb` copies bank `bbb` over all sixteen registers. `busy` stays high for 16 cycles and `res_valid` never rises. After `busy` falls, register `i` reads back bank byte `i`.
- R3: Opcode `1101_0bbb` returns the masked sum of bank `bbb`'s sixteen bytes, modulo 256.
- R4: Opcode `1101_1000` returns one masked sum of all 128 bank bytes, modulo 256, with `busy` high for 128 cycles.
- R5: Before a byte is added, bits 7:4 and bit 0 are cleared at in-bank offset 0, and all eight bits are cleared at offset 4. The same rule applies in every bank.
- R6: `busy` rises in the cycle after the clock edge that accepts the opcode. The result strobe appears in the first cycle in which `busy` is low again, and no strobe appears while `busy` is high.
- R7: `res_valid` is high for exactly one cycle per checksum command.
- R8: An opcode presented while `busy` is high is ignored. The running operation keeps its length and its result.
- R9: An opcode that matches none of the three patterns leaves `busy` low. It produces no strobe and leaves the register file unchanged.
- R10: A side-port write stores a byte into the bank selected by `sp_bank` (when `sp_reg` is 0) or into the register file (when `sp_reg` is 1), at offset `sp_addr`. `sp_rdata` shows the selected byte combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Opcode byte present |
| op_byte | input | 8 | Opcode byte |
| busy | output | 1 | Operation in progress |
| res_valid | output | 1 | One-cycle checksum strobe |
| res_byte | output | 8 | Checksum value |
| sp_we | input | 1 | Side-port write enable |
| sp_reg | input | 1 | 1 selects register file, 0 selects a bank |
| sp_bank | input | 3 | Bank index for side access |
| sp_addr | input | 4 | Byte offset for side access |
| sp_wdata | input | 8 | Side-port write data |
| sp_rdata | output | 8 | Side-port read data |

## Verification
The assertions assume that `op_valid` and all side-port inputs are free of unknowns after reset. They also assume that side writes never occur while `busy` is high, so that the contents seen by a copy or a sum are the contents the host loaded. The stimulus changes inputs only on falling edges. It loads banks and inspects registers only while the engine is idle. It presents opcodes while `busy` is high only in the one test that checks they are dropped.

// File: rtl/cfg_shadow_engine.sv
module cfg_shadow_engine #(
  parameter int NBANK  = 8,
  parameter int NBYTE  = 16,
  parameter int OFS_A  = 0,
  parameter logic [7:0] CLR_A = 8'hF1,
  parameter int OFS_B  = 4,
  parameter logic [7:0] CLR_B = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [7:0] op_byte,
  output logic       busy,
  output logic       res_valid,
  output logic [7:0] res_byte,
  input  logic       sp_we,
  input  logic       sp_reg,
  input  logic [2:0] sp_bank,
  input  logic [3:0] sp_addr,
  input  logic [7:0] sp_wdata,
  output logic [7:0] sp_rdata
);
  localparam int BKW = $clog2(NBANK);
  localparam int BW  = $clog2(NBYTE);
  localparam int TOT = NBANK * NBYTE;
  localparam int IW  = $clog2(TOT);

  typedef enum logic [1:0] {M_COPY, M_BANK, M_ALL} mode_t;

  logic [7:0] ram  [TOT];
  logic [7:0] regs [NBYTE];
  mode_t          mode;
  logic [BKW-1:0] bank;
  logic [IW-1:0]  cnt;
  logic [7:0]     acc;

  wire is_copy = op_byte[7:3] == 5'b11000;
  wire is_bank = op_byte[7:3] == 5'b11010;
  wire is_all  = op_byte == 8'hD8;
  wire known   = is_copy || is_bank || is_all;
  wire accept  = op_valid && !busy && known;

  wire [BW-1:0] off  = cnt[BW-1:0];
  wire [IW-1:0] addr = (mode == M_ALL) ? cnt : {bank, off};
  wire last = (mode == M_ALL) ? (cnt == IW'(TOT - 1)) : (off == BW'(NBYTE - 1));
  wire [7:0] clr = (off == BW'(OFS_A)) ? CLR_A :
                   (off == BW'(OFS_B)) ? CLR_B : 8'h00;
  wire [7:0] sum = acc + (ram[addr] & ~clr);

  wire [IW-1:0] sp_idx = {sp_bank[BKW-1:0], sp_addr[BW-1:0]};
  assign sp_rdata = sp_reg ? regs[sp_addr[BW-1:0]] : ram[sp_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      res_valid <= 1'b0;
      res_byte  <= '0;
      mode      <= M_COPY;
      bank      <= '0;
      cnt       <= '0;
      acc       <= '0;
    end else begin
      res_valid <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        mode <= is_copy ? M_COPY : (is_bank ? M_BANK : M_ALL);
        bank <= op_byte[BKW-1:0];
        cnt  <= '0;
        acc  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        acc <= sum;
        if (last) begin
          busy <= 1'b0;
          if (mode != M_COPY) begin
            res_valid <= 1'b1;
            res_byte  <= sum;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (sp_we && !sp_reg) ram[sp_idx] <= sp_wdata;
  end

  always_ff @(posedge clk) begin
    if (busy && mode == M_COPY) regs[off] <= ram[addr];
    else if (sp_we && sp_reg) regs[sp_addr[BW-1:0]] <= sp_wdata;
  end

  logic [IW:0] span;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) span <= '0;
    else if (accept) span <= '0;
    else if (busy) span <= span + 1'b1;
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !res_valid);
  // R7
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid);
  // R6
  res_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy && $past(busy));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mode) && $stable(bank));
  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !busy && !known |=> !busy && !res_valid);
  // R2
  copy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mode == M_COPY |=> !res_valid);
  // R3
  acc_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> acc == 8'h00);
  // R4
  span_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (span == (IW+1)'(NBYTE) || span == (IW+1)'(TOT)));
endmodule

// File: tb/tb_cfg_shadow_engine.sv
`timescale 1ns/1ps
module tb_cfg_shadow_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] op_byte = '0;
  logic busy, res_valid;
  logic [7:0] res_byte, sp_rdata;
  logic sp_we = 1'b0, sp_reg = 1'b0;
  logic [2:0] sp_bank = '0;
  logic [3:0] sp_addr = '0;
  logic [7:0] sp_wdata = '0;

  int checks = 0, fails = 0;
  logic [7:0] mram [128];
  logic [7:0] mreg [16];

  always #10 clk = ~clk;

  cfg_shadow_engine dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] clrmask(input int a);
    if (a == 0) return 8'hF1;
    if (a == 4) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] bank_sum(input int b);
    logic [7:0] s = 0;
    for (int a = 0; a < 16; a++) s += mram[b*16+a] & ~clrmask(a);
    return s;
  endfunction

  task automatic sp_write(input bit r, input int b, input int a, input logic [7:0] v);
    @(negedge clk);
    sp_we = 1; sp_reg = r; sp_bank = 3'(b); sp_addr = 4'(a); sp_wdata = v;
    @(negedge clk);
    sp_we = 0;
    if (r) mreg[a] = v; else mram[b*16+a] = v;
  endtask

  task automatic check_banks(input string req);
    bit ok = 1; int bad = 0;
    for (int i = 0; i < 128; i++) begin
      sp_reg = 0; sp_bank = 3'(i / 16); sp_addr = 4'(i % 16); #1;
      if (sp_rdata !== mram[i]) begin ok = 0; bad = sp_rdata; end
    end
    chk(ok, req, bad, 0);
  endtask

  task automatic check_regs(input string req);
    bit ok = 1; int bad = 0, want = 0;
    for (int a = 0; a < 16; a++) begin
      sp_reg = 1; sp_addr = 4'(a); #1;
      if (sp_rdata !== mreg[a]) begin ok = 0; bad = sp_rdata; want = mreg[a]; end
    end
    chk(ok, req, bad, want);
  endtask

  task automatic do_op(input logic [7:0] op, input int inj_at, input logic [7:0] inj_op,
                       input int exp_len, input bit exp_res, input logic [7:0] exp_val,
                       input string req);
    int n = 0; bit early = 0;
    @(negedge clk); op_valid = 1; op_byte = op;
    @(negedge clk); op_valid = 0;
    while (busy && n < 1000) begin
      if (res_valid) early = 1;
      if (n == inj_at) begin op_valid = 1; op_byte = inj_op; end else op_valid = 0;
      @(negedge clk); n++;
    end
    op_valid = 0;
    chk(n == exp_len, {req, " R6 busy length"}, n, exp_len);
    chk(!early, "R6 strobe while busy", early, 0);
    chk(res_valid == exp_res, {req, " strobe"}, res_valid, exp_res);
    if (exp_res) chk(res_byte == exp_val, {req, " value"}, res_byte, exp_val);
    @(negedge clk);
    chk(!res_valid, "R7 single strobe", res_valid, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] total;
    repeat (3) @(negedge clk);
    chk(!busy && !res_valid, "R1 reset", {busy, res_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !res_valid, "R1 after release", {busy, res_valid}, 0);
    for (int a = 0; a < 16; a++) sp_write(1, 0, a, 8'(a * 3 + 1));
    check_regs("R10 register side port");

    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 128; i++) begin
        logic [7:0] v;
        case (p)
          0: v = 8'(i);
          1: v = 8'hFF;
          2: v = 8'(i * 37 + 11);
          default: v = 8'((i * i * 7) ^ 8'h5A);
        endcase
        sp_write(0, i / 16, i % 16, v);
      end
      check_banks("R10 bank side port");
      for (int b = 0; b < 8; b++) begin
        do_op(8'hD0 | 8'(b), -1, 8'h00, 16, 1, bank_sum(b), "R3 bank sum");
        do_op(8'hC0 | 8'(b), -1, 8'h00, 16, 0, 8'h00, "R2 copy");
        for (int a = 0; a < 16; a++) mreg[a] = mram[b*16+a];
        check_regs("R2 copy contents");
      end
      total = 0;
      for (int b = 0; b < 8; b++) total += bank_sum(b);
      do_op(8'hD8, -1, 8'h00, 128, 1, total, "R4 all sum");
    end

    for (int i = 0; i < 128; i++) sp_write(0, i / 16, i % 16, 8'h00);
    sp_write(0, 5, 0, 8'hFF);
    sp_write(0, 5, 4, 8'hFF);
    sp_write(0, 5, 1, 8'h03);
    do_op(8'hD5, -1, 8'h00, 16, 1, 8'h11, "R5 masking");
    do_op(8'hD8, -1, 8'h00, 128, 1, 8'h11, "R5 masking all banks");

    for (int a = 0; a < 16; a++) sp_write(0, 2, a, 8'(a + 100));
    do_op(8'hD2, 3, 8'hC2, 16, 1, bank_sum(2), "R8 copy injected");
    check_regs("R8 registers untouched");
    do_op(8'hD2, 7, 8'hD8, 16, 1, bank_sum(2), "R8 sum injected");

    for (int op = 0; op < 256; op++) begin
      logic [7:0] o = 8'(op);
      if (o[7:3] == 5'b11000 || o[7:3] == 5'b11010 || o == 8'hD8) continue;
      @(negedge clk); op_valid = 1; op_byte = o;
      @(negedge clk); op_valid = 0;
      chk(!busy && !res_valid, "R9 unknown opcode", {busy, res_valid}, 0);
    end
    check_regs("R9 registers unchanged");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule